// File: doc/BRIEF.md
# Mode Strap Capture and Instruction-Start Strobe

This block serves a pair of shared pins. While the chip is held in reset, it reads the pins as straps and selects one of four operating modes. It keeps that choice until the next reset. Once reset is released, one of the same pins is reused as a debug output. That output marks the opcode-fetch bus cycle of every instruction.

The debug output is meant for an open-drain style pad. The block produces a pad output-enable and a pad data value. By default the pad only ever pulls low, so several such outputs can share a wired-OR line.

Back-to-back fetch cycles would otherwise merge into one long low interval. An optional drive-high pulse avoids this: after each fetch cycle, the block actively drives the line high for one half-phase of the bus clock and then releases it.

Time is kept in bus cycles of the E clock. A bus cycle begins when E falls. Its first half is E low and its second half is E high. The sequencer supplies a level that is high for the whole of each opcode-fetch bus cycle.

Top module: `mode_strap_strobe`

## Requirements
- R1: `mode_o` takes the value of `strap_in` seen at the last clock edges while `rst_n` is low. With `strap_in` held steady through reset, `mode_o` equals it after release, with bit i taken from pin i.
- R2: After reset is released, `mode_o` stays constant whatever `strap_in` does, until `rst_n` goes low again.
- R3: While `rst_n` is low, `strobe_oe` is 0, so the pad is released and the strap level can be read.
- R4: With the strobe enabled, a bus cycle in which `op_fetch` is 1 gives `strobe_oe`=1 and `strobe_do`=0 (pad pulled low) in both of its halves. The one exception is the first half overridden by R6.
- R5: With the drive-high option off, `strobe_do` is never 1. Outside fetch cycles `strobe_oe` is 0, so consecutive fetch cycles form one unbroken low interval.
- R6: With `pulse_hi_en`=1, the first half (E low) of the bus cycle that follows a fetch cycle gives `strobe_oe`=1 and `strobe_do`=1. This takes precedence over a low request in that half. The second half then follows R4 (low if it is itself a fetch cycle, otherwise released).
- R7: `strobe_do` is 1 only while `strobe_oe` is 1.
- R8: With `strobe_en`=0, `strobe_oe` stays 0 through every bus cycle, fetch or not.
- R9: A bus-cycle boundary is a falling edge of `e_clk`. A rising edge only moves from the first half to the second half and never starts a new low interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the E clock |
| rst_n | input | 1 | Active-low reset; straps are read while it is low |
| strap_in | input | N_PINS | Input levels of the shared mode pins |
| e_clk | input | 1 | Bus clock phase; a fall starts a bus cycle |
| op_fetch | input | 1 | High for the whole of an opcode-fetch bus cycle |
| strobe_en | input | 1 | Enables the instruction-start output |
| pulse_hi_en | input | 1 | Enables the half-phase drive-high after each fetch cycle |
| mode_o | output | N_PINS | Captured operating mode |
| strobe_oe | output | 1 | Pad output enable for the strobe pin |
| strobe_do | output | 1 | Pad data for the strobe pin, valid while enabled |

## Verification
The bench builds the block with two mode pins, two synchronizer stages and the drive-high variant present. The synchronizer puts a three-clock lag between an E edge and the pad response. Each half-phase is held for six clocks, so the lag is exercised while every half still settles before it is sampled. Having the pulse variant elaborated brings within reach the precedence of the high pulse over a back-to-back low, and the merged low interval with the option switched off. Two reset episodes with different strap values show capture and hold.

// File: rtl/msb_pkg.sv
package msb_pkg;

   // Drive request for the strobe pad
   typedef struct packed {
      logic oe;
      logic dat;
   } pad_drv_t;

   localparam int MAX_PINS   = 4;
   localparam int MAX_STAGES = 4;

endpackage

// File: rtl/msb_sync.sv
module msb_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
               stage_q[i] <= stage_q[i-1];
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/msb_mode_latch.sv
module msb_mode_latch #(
   parameter int N_PINS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] strap_s,
   output logic [N_PINS-1:0] mode_q
);

   // Track the straps for as long as reset is held; freeze on release
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= strap_s;
      end
   end

endmodule

// File: rtl/msb_ephase.sv
module msb_ephase (
   input  logic clk,
   input  logic rst_n,
   input  logic e_s,
   output logic e_fall,
   output logic first_half
);

   logic e_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_prev <= 1'b0;
      end else begin
         e_prev <= e_s;
      end
   end

   assign e_fall     = e_prev & ~e_s;
   // Registered E level low means the state registers sit in the first half
   assign first_half = ~e_prev;

endmodule

// File: rtl/msb_strobe_ctl.sv
module msb_strobe_ctl
   import msb_pkg::*;
#(
   parameter int PULSE_OPTION = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     e_fall,
   input  logic     first_half,
   input  logic     fetch_s,
   input  logic     en_s,
   input  logic     hi_s,
   output pad_drv_t drv
);

   logic in_fetch;
   logic was_fetch;
   logic pulse;
   logic low_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_fetch  <= 1'b0;
         was_fetch <= 1'b0;
      end else if (e_fall) begin
         was_fetch <= in_fetch;
         in_fetch  <= fetch_s;
      end
   end

   generate
      if (PULSE_OPTION != 0) begin : g_pulse
         assign pulse = hi_s & was_fetch & first_half;
      end else begin : g_no_pulse
         assign pulse = 1'b0;
      end
   endgenerate

   assign low_req = in_fetch & ~pulse;

   always_comb begin
      drv.oe  = en_s & (low_req | pulse);
      drv.dat = en_s & pulse;
   end

endmodule

// File: rtl/mode_strap_strobe.sv
module mode_strap_strobe
   import msb_pkg::*;
#(
   parameter int N_PINS       = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int PULSE_OPTION = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] strap_in,
   input  logic              e_clk,
   input  logic              op_fetch,
   input  logic              strobe_en,
   input  logic              pulse_hi_en,
   output logic [N_PINS-1:0] mode_o,
   output logic              strobe_oe,
   output logic              strobe_do
);

   localparam int SYNC_W = N_PINS + 4;

   generate
      if (N_PINS < 1 || N_PINS > MAX_PINS) begin : g_bad_pins
         $error("mode_strap_strobe: N_PINS out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_STAGES) begin : g_bad_sync
         $error("mode_strap_strobe: SYNC_STAGES out of range");
      end
      if (PULSE_OPTION < 0 || PULSE_OPTION > 1) begin : g_bad_pulse
         $error("mode_strap_strobe: PULSE_OPTION must be 0 or 1");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_bus;
   logic [SYNC_W-1:0] syn_bus;
   logic [N_PINS-1:0] strap_s;
   logic              e_s;
   logic              fetch_s;
   logic              en_s;
   logic              hi_s;
   logic              e_fall;
   logic              first_half;
   pad_drv_t          drv;

   assign raw_bus = {strap_in, e_clk, op_fetch, strobe_en, pulse_hi_en};

   msb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .din  (raw_bus),
      .dout (syn_bus)
   );

   assign {strap_s, e_s, fetch_s, en_s, hi_s} = syn_bus;

   msb_mode_latch #(.N_PINS(N_PINS)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_s (strap_s),
      .mode_q  (mode_o)
   );

   msb_ephase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .e_s        (e_s),
      .e_fall     (e_fall),
      .first_half (first_half)
   );

   msb_strobe_ctl #(.PULSE_OPTION(PULSE_OPTION)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .e_fall     (e_fall),
      .first_half (first_half),
      .fetch_s    (fetch_s),
      .en_s       (en_s),
      .hi_s       (hi_s),
      .drv        (drv)
   );

   // Pad released while the straps are being read
   assign strobe_oe = rst_n & drv.oe;
   assign strobe_do = rst_n & drv.dat;

endmodule

// File: rtl/msb_checker.sv
module msb_checker #(
   parameter int N_PINS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_PINS-1:0] mode_o,
   input logic              strobe_oe,
   input logic              strobe_do,
   input logic              e_fall,
   input logic              fetch_s,
   input logic              en_s,
   input logic              hi_s
);

   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_o));

   assert_released_in_reset_R3: assert property (@(posedge clk)
      !rst_n |-> !strobe_oe);

   assert_fetch_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      e_fall && fetch_s && en_s && !hi_s |=> strobe_oe && !strobe_do);

   assert_high_needs_option_R6: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_do |-> hi_s);

   assert_high_is_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_do |-> strobe_oe);

   assert_disabled_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |-> !strobe_oe);

endmodule

bind mode_strap_strobe msb_checker #(.N_PINS(N_PINS)) u_msb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_o    (mode_o),
   .strobe_oe (strobe_oe),
   .strobe_do (strobe_do),
   .e_fall    (e_fall),
   .fetch_s   (fetch_s),
   .en_s      (en_s),
   .hi_s      (hi_s)
);

// File: tb/test_mode_strap_strobe.sv
`timescale 1ns/1ps
module test_mode_strap_strobe;

   localparam int NP   = 2;
   localparam int HALF = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] strap_in = '0;
   logic          e_clk = 1'b1;
   logic          op_fetch = 1'b0;
   logic          strobe_en = 1'b0;
   logic          pulse_hi_en = 1'b0;
   logic [NP-1:0] mode_o;
   logic          strobe_oe;
   logic          strobe_do;

   int checks = 0;
   int errors = 0;
   bit prev_fetch = 1'b0;

   typedef struct {
      string tag;
      logic  oe;
      logic  dat;
   } exp_t;

   exp_t exp_q[$];
   event sample_ev;

   always #2.5 clk = ~clk;

   mode_strap_strobe #(.N_PINS(NP), .SYNC_STAGES(2), .PULSE_OPTION(1)) i_mode_strap_strobe (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap_in    (strap_in),
      .e_clk       (e_clk),
      .op_fetch    (op_fetch),
      .strobe_en   (strobe_en),
      .pulse_hi_en (pulse_hi_en),
      .mode_o      (mode_o),
      .strobe_oe   (strobe_oe),
      .strobe_do   (strobe_do)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Monitor: compare pad outputs with the queued expectation
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual sample expected none");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " oe"}, {7'd0, strobe_oe}, {7'd0, e.oe});
            chk({e.tag, " do"}, {7'd0, strobe_do}, {7'd0, e.dat});
         end
      end
   end

   // Driver: one bus cycle, pushing expectations for both halves (R4 R5 R6 R7 R8 R9)
   task automatic ecycle(input bit f, input string tag);
      exp_t h1;
      exp_t h2;
      bit   pl;
      @(negedge clk);
      e_clk    = 1'b0;
      op_fetch = f;
      pl = strobe_en && pulse_hi_en && prev_fetch;
      h1.tag = {tag, " first half"};
      h1.oe  = strobe_en && (pl || f);
      h1.dat = pl;
      h2.tag = {tag, " second half"};
      h2.oe  = strobe_en && f;
      h2.dat = 1'b0;
      prev_fetch = f;
      exp_q.push_back(h1);
      repeat (HALF) @(posedge clk);
      #1 -> sample_ev;
      @(negedge clk);
      e_clk = 1'b1;
      exp_q.push_back(h2);
      repeat (HALF) @(posedge clk);
      #1 -> sample_ev;
   endtask

   task automatic set_cfg(input bit en, input bit hi);
      @(negedge clk);
      strobe_en   = en;
      pulse_hi_en = hi;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset(input logic [NP-1:0] straps);
      @(negedge clk);
      rst_n = 1'b0;
      strap_in = straps;
      prev_fetch = 1'b0;
      for (int i = 0; i < 3; i++) begin
         e_clk = 1'b0;
         op_fetch = 1'b1;
         repeat (3) @(negedge clk);
         chk("R3 oe in reset", {7'd0, strobe_oe}, 8'd0);
         e_clk = 1'b1;
         repeat (3) @(negedge clk);
      end
      op_fetch = 1'b0;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 mode after reset", {{(8-NP){1'b0}}, mode_o}, {{(8-NP){1'b0}}, straps});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      strobe_en = 1'b1;
      do_reset(2'b10);

      // R2: straps move after release
      strap_in = 2'b01;
      set_cfg(1'b1, 1'b0);
      // R4 R5: default low-only, merged back-to-back fetches
      ecycle(1'b1, "R4 fetch");
      ecycle(1'b0, "R5 idle");
      ecycle(1'b0, "R5 idle");
      ecycle(1'b1, "R5 merged a");
      ecycle(1'b1, "R5 merged b");
      ecycle(1'b0, "R5 after");
      chk("R2 mode held", {{(8-NP){1'b0}}, mode_o}, 8'h02);

      // R6 R7 R9: drive-high pulse
      set_cfg(1'b1, 1'b1);
      ecycle(1'b1, "R6 fetch");
      ecycle(1'b0, "R6 pulse");
      ecycle(1'b1, "R9 fetch");
      ecycle(1'b1, "R6 back-to-back");
      ecycle(1'b1, "R7 back-to-back");
      ecycle(1'b0, "R6 tail");
      ecycle(1'b0, "R6 quiet");

      // R8: strobe disabled
      set_cfg(1'b0, 1'b1);
      ecycle(1'b1, "R8 fetch");
      ecycle(1'b1, "R8 fetch");
      ecycle(1'b0, "R8 idle");
      strap_in = 2'b11;
      chk("R2 mode held", {{(8-NP){1'b0}}, mode_o}, 8'h02);

      // second reset episode
      strobe_en = 1'b1;
      pulse_hi_en = 1'b0;
      do_reset(2'b01);
      strap_in = 2'b10;
      ecycle(1'b1, "R4 after reset");
      ecycle(1'b0, "R5 after reset");
      chk("R2 mode held", {{(8-NP){1'b0}}, mode_o}, 8'h01);

      repeat (4) @(negedge clk);
      chk("scoreboard drained", exp_q.size() == 0 ? 8'd1 : 8'd0, 8'd1);
      summary();
      $finish;
   end

endmodule